// File: doc/BRIEF.md
# Multi-Channel Spike Latch Scanner

The block collects narrow pulses from a bank of spike discriminator outputs. Each input passes through a synchroniser and a rising-edge detector. The detected edge then sets a per-channel sticky latch. On every millisecond tick, while no earlier scan is still pending, the block copies all latches into a snapshot. In that same cycle a shared clear resets every latch.

The snapshot is turned into a stream of event codes, which a consumer takes one at a time over a valid/ready handshake. The channels are arranged in groups of eight slots. Each group is configured with how many of its slots are live and with a base code. Live slot `i` of a group reports the code `base + i`.

Each channel also drives an LED output. That output flashes for a configurable number of clock cycles every time a spike edge arrives.

Top module: `spike_scanner`

## Requirements
- R1: After a synchronous active-low reset, `ev_valid` is low and every `led` bit is low.
- R2: An input pulse that is high for at least two clock cycles is held in its channel latch and reported once by the next accepted tick.
- R3: An accepted tick clears every latch. Several pulses on one channel before a tick give a single event. A following tick with no new pulses gives no events.
- R4: Channel `c` belongs to group `c/8` at slot `i = c%8`. Its code is `grp_base[g*CODE_W +: CODE_W] + i`, taken modulo 2^CODE_W.
- R5: The events of one snapshot are emitted in ascending channel order.
- R6: A slot `i` where `i >= grp_width[g*4 +: 4]` never produces an event.
- R7: A tick that arrives while snapshot events are still pending has no effect. Pulses that arrive meanwhile stay latched for the next accepted tick.
- R8: While `ev_valid` is high and `ev_ready` is low, `ev_valid` stays high and `ev_code` does not change.
- R9: Suppose an edge reaches a latch in the same cycle that a tick is accepted. That edge is not in the current snapshot. It is reported by the next accepted tick.
- R10: A spike edge drives its `led` bit high for exactly `LED_CYCLES` cycles. A new edge during the flash restarts the full count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spike_in | input | NUM_GRP*8 | Asynchronous discriminator pulses, one per channel |
| tick_ms | input | 1 | One-cycle scan request, once per millisecond |
| grp_width | input | NUM_GRP*4 | Live slot count per group (values above 8 act as 8) |
| grp_base | input | NUM_GRP*CODE_W | Base event code per group |
| ev_valid | output | 1 | An event code is offered |
| ev_ready | input | 1 | The consumer takes the offered code |
| ev_code | output | CODE_W | Event code |
| led | output | NUM_GRP*8 | Per-channel flash indicator |

## Verification
The bench fires spikes in several patterns and checks what each one reveals:
- A lone channel checks the code arithmetic.
- Scattered channels across all five groups check the ordering and the group mapping.
- Repeated pulses on one channel, followed by an empty scan, separate sticky latching from clearing.
- Pulses on slots past a group's width check the masking.

Two handshake cases are covered. A tick while events are pending, together with a stalled consumer, checks that a busy scan is ignored and that the offered code is held. A spike is timed so that its edge reaches the latch in the capture cycle, which checks that it moves to the next scan rather than being dropped. Single and retriggered LED flashes are measured cycle by cycle.

// File: rtl/spike_pkg.sv
// Package: shared constants for the spike latch scanner.
// Assumes channels are laid out as fixed eight-slot groups.
package spike_pkg;
    localparam int SLOTS_PER_GRP = 8;
    localparam int WIDTH_FIELD_W = 4;
endpackage

// File: rtl/spike_sync_edge.sv
// Module: per-channel two-flop synchroniser plus rising-edge detector.
// Assumes inputs are asynchronous; a pulse held for two clocks is seen.
module spike_sync_edge #(
    parameter int N = 40
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pulse_in,
    output logic [N-1:0] edge_o
);
    logic [N-1:0] meta_q, sync_q, prev_q;

    // Purpose: move inputs into the clock domain and keep a delayed copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pulse_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign edge_o = sync_q & ~prev_q;

    genvar k;
    generate
        for (k = 0; k < N; k++) begin : g_chk
            // R2: a detected edge lasts exactly one cycle
            a_r2_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
                edge_o[k] |=> !edge_o[k]);
        end
    endgenerate
endmodule

// File: rtl/spike_latch_bank.sv
// Module: sticky per-channel latches with a shared clear and a snapshot.
// Assumes pop_i is one-hot or zero and only addresses set snapshot bits.
module spike_latch_bank #(
    parameter int N = 40
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] edge_i,
    input  logic         tick_i,
    input  logic [N-1:0] live_mask_i,
    input  logic [N-1:0] pop_i,
    output logic [N-1:0] snap_o,
    output logic         busy_o
);
    logic [N-1:0] latch_q, snap_q;
    logic         capture;

    assign busy_o  = |snap_q;
    assign capture = tick_i && !busy_o;
    assign snap_o  = snap_q;

    // Purpose: capture-and-clear on an accepted tick, otherwise accumulate edges and retire popped bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
            snap_q  <= '0;
        end else if (capture) begin
            snap_q  <= latch_q & live_mask_i;
            latch_q <= edge_i;
        end else begin
            latch_q <= latch_q | edge_i;
            snap_q  <= snap_q & ~pop_i;
        end
    end

    // R7: while busy, the snapshot only loses bits
    a_r7_busy_shrink: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (snap_q & ~$past(snap_q)) == '0);
    // R2: without a capture, no latch bit is lost
    a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> ($past(latch_q) & ~latch_q) == '0);
    // R6: a fresh snapshot holds only live slots
    a_r6_live_only: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (snap_q & ~$past(live_mask_i)) == '0);
endmodule

// File: rtl/spike_event_emit.sv
// Module: picks the lowest pending snapshot channel and forms its event code.
// Assumes channel c sits in group c/8, slot c%8.
module spike_event_emit #(
    parameter int NUM_GRP = 5,
    parameter int CODE_W  = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_GRP*8-1:0]        snap_i,
    input  logic [NUM_GRP*CODE_W-1:0]   grp_base,
    input  logic                        ev_ready,
    output logic                        ev_valid,
    output logic [CODE_W-1:0]           ev_code,
    output logic [NUM_GRP*8-1:0]        pop_o
);
    import spike_pkg::*;
    localparam int N  = NUM_GRP * SLOTS_PER_GRP;
    localparam int IW = $clog2(N);

    logic [IW-1:0] idx;
    logic          hit;

    // Purpose: priority-select the lowest set snapshot bit.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (snap_i[k]) begin
                hit = 1'b1;
                idx = k[IW-1:0];
            end
        end
    end

    // Purpose: map the selected channel to base plus slot offset.
    always_comb begin
        ev_code = '0;
        for (int g = 0; g < NUM_GRP; g++) begin
            for (int i = 0; i < SLOTS_PER_GRP; i++) begin
                if (idx == IW'(g * SLOTS_PER_GRP + i))
                    ev_code = grp_base[g*CODE_W +: CODE_W] + CODE_W'(i);
            end
        end
    end

    assign ev_valid = hit;

    // Purpose: retire the offered channel once the consumer takes it.
    always_comb begin
        pop_o = '0;
        if (hit && ev_ready) pop_o[idx] = 1'b1;
    end

    // R8: a stalled offer holds steady
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid && !ev_ready |=> ev_valid && $stable(ev_code));
    // R5: the next offer is a higher channel than the one just taken
    a_r5_ascend: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid && ev_ready |=> !ev_valid || (idx > $past(idx)));
endmodule

// File: rtl/spike_led_flash.sv
// Module: retriggerable one-shot per channel for spike indicator LEDs.
// Assumes LEN >= 1; every edge reloads the full duration.
module spike_led_flash #(
    parameter int N   = 40,
    parameter int LEN = 1000000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] edge_i,
    output logic [N-1:0] led_o
);
    localparam int CW = $clog2(LEN + 1);

    genvar k;
    generate
        for (k = 0; k < N; k++) begin : g_ch
            logic [CW-1:0] cnt_q;

            // Purpose: reload on an edge, otherwise count down to zero.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cnt_q <= '0;
                else if (edge_i[k])
                    cnt_q <= CW'(LEN);
                else if (cnt_q != '0)
                    cnt_q <= cnt_q - 1'b1;
            end

            assign led_o[k] = (cnt_q != '0);

            // R10: an edge starts a full-length flash
            a_r10_flash: assert property (@(posedge clk) disable iff (!rst_n)
                edge_i[k] |=> led_o[k] && (cnt_q == CW'(LEN)));
        end
    endgenerate
endmodule

// File: rtl/spike_scanner.sv
// Module: top of the spike latch scanner; wires sync, latches, emitter, LEDs.
// Assumes tick_ms is a one-cycle pulse and configuration is quasi-static.
module spike_scanner #(
    parameter int NUM_GRP    = 5,
    parameter int CODE_W     = 8,
    parameter int LED_CYCLES = 1000000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_GRP*8-1:0]        spike_in,
    input  logic                        tick_ms,
    input  logic [NUM_GRP*4-1:0]        grp_width,
    input  logic [NUM_GRP*CODE_W-1:0]   grp_base,
    output logic                        ev_valid,
    input  logic                        ev_ready,
    output logic [CODE_W-1:0]           ev_code,
    output logic [NUM_GRP*8-1:0]        led
);
    import spike_pkg::*;
    localparam int N = NUM_GRP * SLOTS_PER_GRP;

    logic [N-1:0] edges, live_mask, snap, pop;
    logic         busy;

    genvar g, i;
    generate
        for (g = 0; g < NUM_GRP; g++) begin : g_grp
            for (i = 0; i < SLOTS_PER_GRP; i++) begin : g_slot
                assign live_mask[g*SLOTS_PER_GRP + i] =
                    (grp_width[g*WIDTH_FIELD_W +: WIDTH_FIELD_W] > WIDTH_FIELD_W'(i));
            end
        end
    endgenerate

    spike_sync_edge #(.N(N)) u_sync (
        .clk(clk), .rst_n(rst_n), .pulse_in(spike_in), .edge_o(edges)
    );

    spike_latch_bank #(.N(N)) u_bank (
        .clk(clk), .rst_n(rst_n), .edge_i(edges), .tick_i(tick_ms),
        .live_mask_i(live_mask), .pop_i(pop), .snap_o(snap), .busy_o(busy)
    );

    spike_event_emit #(.NUM_GRP(NUM_GRP), .CODE_W(CODE_W)) u_emit (
        .clk(clk), .rst_n(rst_n), .snap_i(snap), .grp_base(grp_base),
        .ev_ready(ev_ready), .ev_valid(ev_valid), .ev_code(ev_code), .pop_o(pop)
    );

    spike_led_flash #(.N(N), .LEN(LED_CYCLES)) u_led (
        .clk(clk), .rst_n(rst_n), .edge_i(edges), .led_o(led)
    );

    // R7: a tick during a pending scan does not refill it
    a_r7_tick_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        tick_ms && busy |=> $countones(snap) <= $countones($past(snap)));
endmodule

// File: tb/sim_spike_scanner.sv
module sim_spike_scanner;
    localparam int NG = 5;
    localparam int CW = 8;
    localparam int NC = NG * 8;
    localparam int LEDN = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NC-1:0]     spike_in = '0;
    logic              tick_ms = 1'b0;
    logic [NG*4-1:0]   grp_width;
    logic [NG*CW-1:0]  grp_base;
    logic              ev_valid, ev_ready;
    logic [CW-1:0]     ev_code;
    logic [NC-1:0]     led;

    int checks = 0;
    int errors = 0;
    int wid[NG] = '{4, 4, 8, 8, 8};
    int bas[NG] = '{1, 5, 111, 119, 127};

    always #10 clk = ~clk;

    spike_scanner #(.NUM_GRP(NG), .CODE_W(CW), .LED_CYCLES(LEDN)) u0 (
        .clk(clk), .rst_n(rst_n), .spike_in(spike_in), .tick_ms(tick_ms),
        .grp_width(grp_width), .grp_base(grp_base), .ev_valid(ev_valid),
        .ev_ready(ev_ready), .ev_code(ev_code), .led(led)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse(input logic [NC-1:0] m);
        @(negedge clk) spike_in = m;
        repeat (2) @(negedge clk);
        spike_in = '0;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_tick();
        @(negedge clk) tick_ms = 1'b1;
        @(negedge clk) tick_ms = 1'b0;
    endtask

    task automatic drain_and_compare(input string req, input logic [NC-1:0] m);
        int got[$];
        int exp[$];
        int idle = 0;
        for (int c = 0; c < NC; c++)
            if ((c % 8) < wid[c / 8]) begin
                if (m[c]) exp.push_back((bas[c / 8] + c % 8) % 256);
            end
        ev_ready = 1'b1;
        for (int t = 0; t < 200 && idle < 4; t++) begin
            if (ev_valid) begin
                got.push_back(int'(ev_code));
                idle = 0;
            end else idle++;
            @(negedge clk);
        end
        chk({req, " count"}, got.size(), exp.size());
        for (int k = 0; k < exp.size() && k < got.size(); k++)
            chk({req, " code"}, got[k], exp[k]);
    endtask

    task automatic t_reset();
        chk("R1 valid", int'(ev_valid), 0);
        chk("R1 led", int'(led != '0), 0);
    endtask

    task automatic t_single();   // R2 R4
        logic [NC-1:0] m = '0;
        m[2] = 1'b1;
        pulse(m);
        do_tick();
        drain_and_compare("R2 R4 single", m);
    endtask

    task automatic t_order();    // R5 R4 across all groups
        logic [NC-1:0] m = '0;
        m[39] = 1'b1; m[1] = 1'b1; m[20] = 1'b1; m[9] = 1'b1; m[24] = 1'b1;
        pulse(m);
        do_tick();
        drain_and_compare("R5 ascending", m);
    endtask

    task automatic t_clear();    // R3
        logic [NC-1:0] m = '0;
        m[16] = 1'b1;
        pulse(m);
        pulse(m);
        do_tick();
        drain_and_compare("R3 one event", m);
        do_tick();
        drain_and_compare("R3 cleared", '0);
    endtask

    task automatic t_mask();     // R6
        logic [NC-1:0] m = '0;
        m[5] = 1'b1; m[13] = 1'b1; m[7] = 1'b1;
        pulse(m);
        do_tick();
        drain_and_compare("R6 masked", '0);
    endtask

    task automatic t_busy();     // R7 R8
        logic [NC-1:0] m = '0;
        logic [NC-1:0] late = '0;
        m[0] = 1'b1; m[1] = 1'b1;
        late[3] = 1'b1;
        ev_ready = 1'b0;
        pulse(m);
        do_tick();
        for (int k = 0; k < 4; k++) begin
            chk("R8 valid held", int'(ev_valid), 1);
            chk("R8 code held", int'(ev_code), 1);
            @(negedge clk);
        end
        pulse(late);
        do_tick();
        drain_and_compare("R7 busy tick ignored", m);
        do_tick();
        drain_and_compare("R7 late spike kept", late);
    endtask

    task automatic t_capture_edge();  // R9
        logic [NC-1:0] m = '0;
        m[2] = 1'b1;
        @(negedge clk) spike_in = m;
        @(negedge clk);
        @(negedge clk) tick_ms = 1'b1;
        @(negedge clk) begin tick_ms = 1'b0; spike_in = '0; end
        chk("R9 not in current scan", int'(ev_valid), 0);
        repeat (3) @(negedge clk);
        do_tick();
        drain_and_compare("R9 next scan", m);
    endtask

    task automatic t_led();      // R10
        int hi = 0;
        repeat (LEDN + 5) @(negedge clk);
        chk("R10 led idle", int'(led[30]), 0);
        @(negedge clk) spike_in[30] = 1'b1;
        for (int n = 0; n < 30; n++) begin
            if (n == 2) spike_in[30] = 1'b0;
            if (led[30]) hi++;
            @(negedge clk);
        end
        chk("R10 single flash", hi, LEDN);
        hi = 0;
        spike_in[30] = 1'b1;
        for (int n = 0; n < 40; n++) begin
            if (n == 2) spike_in[30] = 1'b0;
            if (n == 5) spike_in[30] = 1'b1;
            if (n == 7) spike_in[30] = 1'b0;
            if (led[30]) hi++;
            @(negedge clk);
        end
        chk("R10 retrigger", hi, LEDN + 5);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        for (int g = 0; g < NG; g++) begin
            grp_width[g*4 +: 4] = 4'(wid[g]);
            grp_base[g*CW +: CW] = CW'(bas[g]);
        end
        ev_ready = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_single();
        t_order();
        t_clear();
        t_mask();
        t_busy();
        t_capture_edge();
        t_led();
        finish_run();
    end

    initial begin
        #(200000 * 20);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end
endmodule